// File: doc/BRIEF.md
# Registered-Input Synchronous Dual-Port RAM

This block is a shared storage array of 4096 words, each 9 bits wide, reached through two independent access ports, A and B. Every control and data input of a port is captured in an input register on the rising clock edge. The access then runs from those registered values. A write commits the registered data to the registered address at the next edge. A read places the addressed word on the port output one clock after the address was captured.

A per-port clock enable freezes only the address and write-data registers. It does not gate the clock. The select and direction registers keep sampling, so a stalled port repeats its access on the held address and data. Each port's output is gated by an active-low output enable that acts at once, with no clock edge needed. A disabled output is modelled as a low valid flag with the data bus forced to zero, in place of a high-impedance bus.

Both ports run from one shared clock, so a collision between them is well defined. When both ports write the same word in the same cycle, port A's data is kept. A read of a word that the other port writes in the same cycle returns the old contents. The ports have no back-pressure: an access cannot be refused, and the only way to stall a port is its clock enable.

Top module: `dual_port_reg_ram`

## Requirements
- R1: While reset is asserted and until the first read completes, both ports show valid low and data zero, and the select register reads as deselected.
- R2: A write captured at edge k (chip enable low, write-enable low) is stored by edge k+1, and it is readable afterwards from either port. Writes from the two ports to different addresses in the same cycle both land.
- R3: A read captured at edge k (chip enable low, write-enable high) shows valid high and the stored word on the port output after edge k+1, while output enable is low. After a write cycle the port output is invalid.
- R4: Raising the active-low output enable forces valid low and data zero immediately, with no clock edge. Lowering it restores the held read word at once.
- R5: A port whose chip enable was high at the capturing edge performs no write, whatever its write-enable says. From the following edge on, that port's output is invalid.
- R6: When the clock enable is low at an edge, the address and write-data registers keep their previous values. The access sampled at that edge therefore uses the held address and held data.
- R7: When both ports write the same address in the same cycle, the word keeps port A's data.
- R8: When one port reads an address that the other port writes in the same cycle, the read returns the contents from before the write.
- R9: Whenever a port's valid flag is low, its data bus is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; all registers capture on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_ce_n | input | 1 | Port A chip enable, active low |
| a_we_n | input | 1 | Port A direction: low writes, high reads |
| a_clken | input | 1 | Port A clock enable for address and write-data registers |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_addr | input | 12 | Port A word address |
| a_wdata | input | 9 | Port A write data |
| a_rdata | output | 9 | Port A read data, zero when not valid |
| a_rvalid | output | 1 | Port A output-driven flag |
| b_ce_n | input | 1 | Port B chip enable, active low |
| b_we_n | input | 1 | Port B direction: low writes, high reads |
| b_clken | input | 1 | Port B clock enable for address and write-data registers |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_addr | input | 12 | Port B word address |
| b_wdata | input | 9 | Port B write data |
| b_rdata | output | 9 | Port B read data, zero when not valid |
| b_rvalid | output | 1 | Port B output-driven flag |

## Verification
Three pairs of events can fall in the same cycle: two writes to one word, a write on one port with a read of the same word on the other, and writes from both ports to different words. Each case is provoked by driving both ports at the same falling edge so that both accesses are captured by one rising edge. Same-word writes are judged by reading the word back later and expecting port A's value. The same-cycle read must return the value written before the collision, and a later read must return the new value. Writes to different words are judged by reading each word back from the opposite port.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  // Registered access control of one port.
  typedef struct packed {
    logic sel;  // port selected (chip enable was active)
    logic wr;   // direction captured as write
  } acc_ctl_t;

  localparam int NUM_PORTS = 2;
endpackage

// File: rtl/dpram_in_stage.sv
module dpram_in_stage
  import dpram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          clken,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output acc_ctl_t      ctl_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  // Control is always sampled; clken stalls only address and data.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{sel: 1'b0, wr: 1'b0};
    end else begin
      ctl_q <= '{sel: ~ce_n, wr: ~we_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (clken) begin
      addr_q <= addr;
      data_q <= wdata;
    end
  end

  // R6: a stalled edge leaves the address and data registers untouched
  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clken |=> (addr_q == $past(addr_q)) && (data_q == $past(data_q)));

  // R6: an enabled edge takes the port values
  p_enabled_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clken |=> (addr_q == $past(addr)) && (data_q == $past(wdata)));
endmodule

// File: rtl/dpram_store.sv
module dpram_store
  import dpram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_ctl_t      a_ctl,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_din,
  input  acc_ctl_t      b_ctl,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_din,
  output logic [DW-1:0] a_rd,
  output logic [DW-1:0] b_rd
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic a_wr, b_wr, same_word;

  assign a_wr      = a_ctl.sel & a_ctl.wr;
  assign b_wr      = b_ctl.sel & b_ctl.wr;
  assign same_word = (a_addr == b_addr);

  // Reads sample the array before this edge's writes take effect (old data).
  always_ff @(posedge clk) begin
    a_rd <= mem[a_addr];
    b_rd <= mem[b_addr];
  end

  // B is written first so that A, assigned later, wins a same-word collision.
  always_ff @(posedge clk) begin
    if (b_wr) mem[b_addr] <= b_din;
    if (a_wr) mem[a_addr] <= a_din;
  end

  // R7: port A's data survives a same-word double write
  p_a_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && b_wr && same_word) |=> mem[$past(a_addr)] == $past(a_din));

  // R2: a port A write always lands
  p_a_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr |=> mem[$past(a_addr)] == $past(a_din));

  // R2: a port B write lands unless A overrides the same word
  p_b_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (b_wr && !(a_wr && same_word)) |=> mem[$past(b_addr)] == $past(b_din));
endmodule

// File: rtl/dpram_out_gate.sv
module dpram_out_gate
  import dpram_pkg::*;
#(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_ctl_t      ctl_q,
  input  logic [DW-1:0] rd_word,
  input  logic          oe_n,
  output logic          rvalid,
  output logic [DW-1:0] rdata
);
  logic rd_pend;

  // Read word is held by the store; this flag marks it as a completed read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= ctl_q.sel & ~ctl_q.wr;
  end

  // Output enable acts without any clock edge.
  assign rvalid = rd_pend & ~oe_n;
  assign rdata  = rvalid ? rd_word : '0;

  // R5: a deselected capture leaves the output dark after the next edge
  p_desel_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q.sel |=> !rvalid);

  // R3: a captured write leaves the output dark after the next edge
  p_write_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.sel && ctl_q.wr) |=> !rvalid);

  // R4, R9: an inactive output enable blanks flag and data at once
  always_comb begin
    if (rst_n && oe_n) begin
      p_oe_blank_r4: assert (!rvalid && rdata == '0);
    end
  end
endmodule

// File: rtl/dual_port_reg_ram.sv
module dual_port_reg_ram
  import dpram_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_ce_n,
  input  logic          a_we_n,
  input  logic          a_clken,
  input  logic          a_oe_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_rvalid,
  input  logic          b_ce_n,
  input  logic          b_we_n,
  input  logic          b_clken,
  input  logic          b_oe_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_rvalid
);
  logic          ce_n_v  [NUM_PORTS];
  logic          we_n_v  [NUM_PORTS];
  logic          clken_v [NUM_PORTS];
  logic          oe_n_v  [NUM_PORTS];
  logic [AW-1:0] addr_v  [NUM_PORTS];
  logic [DW-1:0] wdat_v  [NUM_PORTS];
  acc_ctl_t      ctl_q   [NUM_PORTS];
  logic [AW-1:0] addr_q  [NUM_PORTS];
  logic [DW-1:0] data_q  [NUM_PORTS];
  logic [DW-1:0] rd_word [NUM_PORTS];
  logic          valid_v [NUM_PORTS];
  logic [DW-1:0] rdat_v  [NUM_PORTS];

  assign ce_n_v[0]  = a_ce_n;   assign ce_n_v[1]  = b_ce_n;
  assign we_n_v[0]  = a_we_n;   assign we_n_v[1]  = b_we_n;
  assign clken_v[0] = a_clken;  assign clken_v[1] = b_clken;
  assign oe_n_v[0]  = a_oe_n;   assign oe_n_v[1]  = b_oe_n;
  assign addr_v[0]  = a_addr;   assign addr_v[1]  = b_addr;
  assign wdat_v[0]  = a_wdata;  assign wdat_v[1]  = b_wdata;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dpram_in_stage #(.AW(AW), .DW(DW)) u_in (
      .clk(clk), .rst_n(rst_n),
      .ce_n(ce_n_v[p]), .we_n(we_n_v[p]), .clken(clken_v[p]),
      .addr(addr_v[p]), .wdata(wdat_v[p]),
      .ctl_q(ctl_q[p]), .addr_q(addr_q[p]), .data_q(data_q[p])
    );

    dpram_out_gate #(.DW(DW)) u_out (
      .clk(clk), .rst_n(rst_n),
      .ctl_q(ctl_q[p]), .rd_word(rd_word[p]), .oe_n(oe_n_v[p]),
      .rvalid(valid_v[p]), .rdata(rdat_v[p])
    );
  end

  dpram_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_ctl(ctl_q[0]), .a_addr(addr_q[0]), .a_din(data_q[0]),
    .b_ctl(ctl_q[1]), .b_addr(addr_q[1]), .b_din(data_q[1]),
    .a_rd(rd_word[0]), .b_rd(rd_word[1])
  );

  assign a_rvalid = valid_v[0];
  assign a_rdata  = rdat_v[0];
  assign b_rvalid = valid_v[1];
  assign b_rdata  = rdat_v[1];

  // R1: the select registers come out of reset deselected
  p_reset_desel_r1: assert property (@(posedge clk)
    !rst_n |=> !ctl_q[0].sel && !ctl_q[1].sel);
endmodule

// File: tb/dual_port_reg_ram_bench.sv
module dual_port_reg_ram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 9;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_ce_n = 1'b1, a_we_n = 1'b1, a_clken = 1'b1, a_oe_n = 1'b0;
  logic b_ce_n = 1'b1, b_we_n = 1'b1, b_clken = 1'b1, b_oe_n = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_rvalid, b_rvalid;

  int vectors = 0;
  int misses  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_port_reg_ram #(.AW(AW), .DW(DW)) u_dual_port_reg_ram (
    .clk(clk), .rst_n(rst_n),
    .a_ce_n(a_ce_n), .a_we_n(a_we_n), .a_clken(a_clken), .a_oe_n(a_oe_n),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_ce_n(b_ce_n), .b_we_n(b_we_n), .b_clken(b_clken), .b_oe_n(b_oe_n),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  function automatic int pat(int i);
    return (i * 37 + 5) & ((1 << DW) - 1);
  endfunction

  // Observed port value: valid flag above the data bits.
  function automatic int obs_a();
    return {a_rvalid, a_rdata};
  endfunction
  function automatic int obs_b();
    return {b_rvalid, b_rdata};
  endfunction
  function automatic int rd(int d);
    return (1 << DW) | d;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive_a(bit ce_n, bit we_n, bit en, int ad, int d);
    a_ce_n = ce_n; a_we_n = we_n; a_clken = en;
    a_addr = AW'(ad); a_wdata = DW'(d);
  endtask
  task automatic drive_b(bit ce_n, bit we_n, bit en, int ad, int d);
    b_ce_n = ce_n; b_we_n = we_n; b_clken = en;
    b_addr = AW'(ad); b_wdata = DW'(d);
  endtask
  task automatic idle();
    drive_a(1, 1, 1, 0, 0);
    drive_b(1, 1, 1, 0, 0);
  endtask

  task automatic expect_a(string tag, int ad, int d);
    drive_a(0, 1, 1, ad, 0); step();
    drive_a(1, 1, 1, 0, 0);  step();
    chk(tag, obs_a(), rd(d));
  endtask
  task automatic expect_b(string tag, int ad, int d);
    drive_b(0, 1, 1, ad, 0); step();
    drive_b(1, 1, 1, 0, 0);  step();
    chk(tag, obs_b(), rd(d));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // R1: outputs dark in and after reset
    repeat (3) step();
    chk("R1 A dark in reset", obs_a(), 0);
    chk("R1 B dark in reset", obs_b(), 0);
    rst_n = 1'b1;
    step(); step();
    chk("R1 A dark after reset", obs_a(), 0);
    chk("R1 B dark after reset", obs_b(), 0);

    // R2: fill the whole array from port A
    for (int i = 0; i < N; i++) begin
      drive_a(0, 0, 1, i, pat(i));
      step();
      // R3: a write cycle leaves the output invalid
      if (i >= 1) chk("R3 A dark during writes", obs_a(), 0);
    end
    idle(); step(); step();

    // R2, R3: pipelined sweep, B ascending and A descending
    for (int i = 0; i <= N; i++) begin
      if (i < N) begin
        drive_b(0, 1, 1, i, 0);
        drive_a(0, 1, 1, N - 1 - i, 0);
      end else begin
        idle();
      end
      step();
      if (i >= 1) begin
        chk("R2 R3 B sweep read", obs_b(), rd(pat(i - 1)));
        chk("R2 R3 A sweep read", obs_a(), rd(pat(N - i)));
      end
    end
    step();
    chk("R5 A dark when deselected", obs_a(), 0);
    chk("R9 B dark when deselected", obs_b(), 0);

    // R4: output enable acts between edges
    drive_b(0, 1, 1, 5, 0);
    step(); step();
    chk("R3 B held read", obs_b(), rd(pat(5)));
    #(CLK_PERIOD/5);
    b_oe_n = 1'b1;
    #1;
    chk("R4 R9 B blanked by oe", obs_b(), 0);
    b_oe_n = 1'b0;
    #1;
    chk("R4 B restored by oe", obs_b(), rd(pat(5)));
    step();

    // R5: deselect drops a valid read on the following edge
    drive_b(0, 1, 1, 9, 0); step();
    drive_b(1, 1, 1, 9, 0); step();
    chk("R5 B read before deselect", obs_b(), rd(pat(9)));
    step();
    chk("R5 B dark after deselect", obs_b(), 0);

    // R5: a deselected write stores nothing
    drive_b(1, 0, 1, 7, 'h1FF); step();
    idle(); step();
    chk("R5 B dark on deselected write", obs_b(), 0);
    expect_a("R5 no deselected write", 7, pat(7));

    // R6: held address is reused for a stalled read
    drive_a(0, 0, 1, 10, 'h0AA); step();
    drive_a(0, 1, 0, 20, 0);     step();
    idle();                      step();
    chk("R6 stalled read uses held address", obs_a(), rd('h0AA));

    // R6: held data is reused for a stalled write
    drive_a(0, 0, 1, 30, 'h055); step();
    drive_a(0, 0, 0, 40, 'h133); step();
    idle(); step();
    expect_b("R6 held data at held address", 30, 'h055);
    expect_b("R6 new address untouched", 40, pat(40));

    // R7: same-word double write keeps port A data
    drive_a(0, 0, 1, 100, 'h011);
    drive_b(0, 0, 1, 100, 'h122);
    step();
    idle(); step();
    expect_a("R7 A wins collision", 100, 'h011);

    // R2: different-word writes in one cycle both land
    drive_a(0, 0, 1, 300, 'h0F0);
    drive_b(0, 0, 1, 301, 'h10F);
    step();
    idle(); step();
    expect_b("R2 A word via B", 300, 'h0F0);
    expect_a("R2 B word via A", 301, 'h10F);

    // R8: read of a word written by the other port returns old contents
    drive_a(0, 0, 1, 200, 'h1EE);
    drive_b(0, 1, 1, 200, 0);
    step();
    idle(); step();
    chk("R8 B reads old word", obs_b(), rd(pat(200)));
    expect_b("R8 new word afterwards", 200, 'h1EE);

    drive_b(0, 0, 1, 201, 'h0C3);
    drive_a(0, 1, 1, 201, 0);
    step();
    idle(); step();
    chk("R8 A reads old word", obs_a(), rd(pat(201)));
    expect_a("R8 new word afterwards A", 201, 'h0C3);

    step();
    chk("R9 A dark at end", obs_a(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule